// File: doc/BRIEF.md
# Presence-Detect EEPROM Reader

This block fetches the 64-byte configuration table held in the small serial EEPROM of a memory module and checks it. A one-cycle start pulse launches a fixed command sequence towards a byte-level I2C master. First it makes a write-direction addressing pass that loads the EEPROM's internal pointer with zero. A repeated START then turns the bus round to read direction, and 64 sequential byte reads follow. The block holds no bit-level bus timing. It only issues commands and waits for the master's completion handshake.

While the bytes stream in, the block stores each one in a local register array and keeps a modulo-256 sum of every byte before the last. The last byte is the stored checksum, and it is compared against that sum. When the run ends the block drops busy and pulses done for one cycle. Exactly one of three sticky outcome flags is then set: pass, checksum mismatch, or abort. Every command wait is bounded by a cycle limit. A slave that does not acknowledge during addressing also aborts the run, after a STOP has been sent. Software or a boot sequencer reads the captured table back through a 6-bit address port.

Top module: `spd_eeprom_reader`

## Requirements
- R1: A start pulse while idle makes busy high on the next cycle and clears all three outcome flags. A start pulse while busy is ignored: the running sequence neither restarts nor gains commands.
- R2: The first command is a write (op code 0) with the start flag set and data 0xA2, meaning device address with bit 0 = 0 for write. The second is a write with the start flag clear and data 0x00, which sets the EEPROM pointer. No STOP is sent between them.
- R3: The third command is a write with the start flag set and data 0xA3, the device address with bit 0 = 1 for read.
- R4: Exactly 64 read commands (op code 1) follow, none with the start flag. Reads 1 to 63 have nack and stop low. Read 64 has nack and stop both high. A clean run has 67 commands in total.
- R5: After a run that completes all reads, the read port returns the byte received in read n (1-based) at address n-1, for all 64 addresses.
- R6: The modulo-256 sum of the first 63 bytes is compared with byte 64. If they are equal, ok is set. Otherwise cksum_err is set.
- R7: A command whose done has not arrived in the cycle TIMEOUT_LIMIT after cmd_valid rose is abandoned. cmd_valid drops, no further command is issued, and timeout_err is set. A done in the cycle before that limit is accepted.
- R8: If cmd_ack is low when any of the three write commands completes, the block issues one STOP-only command (op code 2, stop flag set) and then ends with timeout_err set.
- R9: done is high for exactly one cycle, in the first cycle with busy low. At that point exactly one of ok, cksum_err and timeout_err is set, and the flags hold until the next accepted start.
- R10: While cmd_valid is high and neither done nor the timeout has been reached, the command fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Sticky: checksum matched |
| cksum_err_o | output | 1 | Sticky: checksum mismatch |
| timeout_err_o | output | 1 | Sticky: wait limit reached or address/pointer not acknowledged |
| rd_addr_i | input | 6 | Captured-byte read address |
| rd_data_o | output | 8 | Captured byte at rd_addr_i |
| cmd_valid_o | output | 1 | Command request, held until cmd_done_i |
| cmd_op_o | output | 2 | 0 write byte, 1 read byte, 2 STOP only |
| cmd_start_o | output | 1 | Precede the byte with a (repeated) START |
| cmd_stop_o | output | 1 | Follow the command with STOP |
| cmd_nack_o | output | 1 | Answer the read byte with NACK |
| cmd_wdata_o | output | 8 | Byte to transmit |
| cmd_done_i | input | 1 | Command completed |
| cmd_ack_i | input | 1 | Slave acknowledged the written byte |
| cmd_rdata_i | input | 8 | Received byte, valid with cmd_done_i |

## Verification
The responder model plays the EEPROM and serves its contents from a pointer set by the pointer write. So a wrong byte order, a missing pointer reset or a stray restart shows up as wrong captured bytes as well as a wrong command log. Tables from several seeds are run both with a correct final byte and with a flipped bit in it, which separates a sum that wrongly includes or drops a byte from a correct one. Response delays of zero, one, two and limit-minus-one cycles, and then exactly the limit, mark the timeout boundary. Stalls at the addressing commands, at a mid-table read and at the last read, together with a missing acknowledge at each of the three write steps, separate a silent abort from the abort that sends STOP first.

// File: rtl/spd_reader_pkg.sv
package spd_reader_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_STOP  = 2'd2
    } spd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_W,
        ST_PTR,
        ST_ADDR_R,
        ST_READ,
        ST_STOP
    } spd_state_e;

endpackage

// File: rtl/spd_checksum.sv
module spd_checksum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       add_i,
    input  logic       check_i,
    input  logic [7:0] byte_i,
    output logic       mismatch_o
);

    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clear_i) begin
            sum_d = '0;
        end else if (add_i) begin
            sum_d = sum_q + byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign mismatch_o = check_i && (byte_i != sum_q);

    AST_CLEAR_ZEROES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sum_q == 8'd0)); // R6

    AST_CHECK_FREEZES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && !add_i && !clear_i) |=> $stable(sum_q)); // R6

endmodule

// File: rtl/spd_capture.sv
module spd_capture #(
    parameter int NUM_BYTES = 64,
    localparam int IDX_W = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [7:0]       wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [7:0]       rdata_o
);

    logic [7:0] mem_d [NUM_BYTES];
    logic [7:0] mem_q [NUM_BYTES];

    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

    AST_CAPTURE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(widx_i)] == $past(wdata_i))); // R5

endmodule

// File: rtl/spd_sequencer.sv
module spd_sequencer
    import spd_reader_pkg::*;
#(
    parameter int         NUM_BYTES     = 64,
    parameter logic [7:0] DEV_ADDR      = 8'hA2,
    parameter int         TIMEOUT_W     = 16,
    parameter int         TIMEOUT_LIMIT = 65535,
    localparam int        IDX_W         = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmd_done_i,
    input  logic             cmd_ack_i,
    input  logic             cs_mismatch_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ok_o,
    output logic             cks_err_o,
    output logic             to_err_o,
    output logic             cmd_valid_o,
    output logic [1:0]       cmd_op_o,
    output logic             cmd_start_o,
    output logic             cmd_stop_o,
    output logic             cmd_nack_o,
    output logic [7:0]       cmd_wdata_o,
    output logic             cap_we_o,
    output logic [IDX_W-1:0] cap_idx_o,
    output logic             cs_clear_o,
    output logic             cs_add_o,
    output logic             cs_check_o
);

    localparam logic [IDX_W-1:0]     LAST_IDX = IDX_W'(NUM_BYTES - 1);
    localparam logic [TIMEOUT_W-1:0] WAIT_MAX = TIMEOUT_W'(TIMEOUT_LIMIT - 1);
    localparam logic [7:0]           ADDR_WR  = {DEV_ADDR[7:1], 1'b0};
    localparam logic [7:0]           ADDR_RD  = {DEV_ADDR[7:1], 1'b1};

    typedef struct packed {
        spd_state_e           st;
        logic [IDX_W-1:0]     idx;
        logic [TIMEOUT_W-1:0] wcnt;
        logic                 ok;
        logic                 cks;
        logic                 to;
        logic                 done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      waiting;
    logic      last_rd;

    assign waiting = (r_q.st != ST_IDLE);
    assign last_rd = (r_q.idx == LAST_IDX);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (start_i) begin
                r_d.st   = ST_ADDR_W;
                r_d.idx  = '0;
                r_d.wcnt = '0;
                r_d.ok   = 1'b0;
                r_d.cks  = 1'b0;
                r_d.to   = 1'b0;
            end
        end else if (cmd_done_i) begin
            r_d.wcnt = '0;
            unique case (r_q.st)
                ST_ADDR_W: r_d.st = cmd_ack_i ? ST_PTR    : ST_STOP;
                ST_PTR:    r_d.st = cmd_ack_i ? ST_ADDR_R : ST_STOP;
                ST_ADDR_R: r_d.st = cmd_ack_i ? ST_READ   : ST_STOP;
                ST_READ: begin
                    if (last_rd) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.ok   = !cs_mismatch_i;
                        r_d.cks  = cs_mismatch_i;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.to   = 1'b1;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end else if (r_q.wcnt == WAIT_MAX) begin
            r_d.st   = ST_IDLE;
            r_d.wcnt = '0;
            r_d.done = 1'b1;
            r_d.to   = 1'b1;
        end else begin
            r_d.wcnt = r_q.wcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, idx: '0, wcnt: '0, ok: 1'b0,
                     cks: 1'b0, to: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cmd_valid_o = waiting;
        cmd_op_o    = OP_WRITE;
        cmd_start_o = 1'b0;
        cmd_stop_o  = 1'b0;
        cmd_nack_o  = 1'b0;
        cmd_wdata_o = 8'h00;
        unique case (r_q.st)
            ST_ADDR_W: begin
                cmd_start_o = 1'b1;
                cmd_wdata_o = ADDR_WR;
            end
            ST_ADDR_R: begin
                cmd_start_o = 1'b1;
                cmd_wdata_o = ADDR_RD;
            end
            ST_READ: begin
                cmd_op_o   = OP_READ;
                cmd_nack_o = last_rd;
                cmd_stop_o = last_rd;
            end
            ST_STOP: begin
                cmd_op_o   = OP_STOP;
                cmd_stop_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o     = waiting;
    assign done_o     = r_q.done;
    assign ok_o       = r_q.ok;
    assign cks_err_o  = r_q.cks;
    assign to_err_o   = r_q.to;
    assign cap_we_o   = (r_q.st == ST_READ) && cmd_done_i;
    assign cap_idx_o  = r_q.idx;
    assign cs_clear_o = (r_q.st == ST_IDLE) && start_i;
    assign cs_add_o   = cap_we_o && !last_rd;
    assign cs_check_o = cap_we_o && last_rd;

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wcnt <= WAIT_MAX); // R7

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_done_i && (r_q.wcnt != WAIT_MAX)) |=>
        (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_wdata_o) &&
         $stable(cmd_start_o) && $stable(cmd_stop_o) && $stable(cmd_nack_o))); // R10

    AST_READ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == OP_READ) |-> !cmd_start_o); // R4

    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !cmd_done_i && (r_q.wcnt != WAIT_MAX)) |=> busy_o); // R1

endmodule

// File: rtl/spd_eeprom_reader.sv
module spd_eeprom_reader #(
    parameter int         NUM_BYTES     = 64,
    parameter logic [7:0] DEV_ADDR      = 8'hA2,
    parameter int         TIMEOUT_W     = 16,
    parameter int         TIMEOUT_LIMIT = 65535,
    localparam int        IDX_W         = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ok_o,
    output logic             cksum_err_o,
    output logic             timeout_err_o,
    input  logic [IDX_W-1:0] rd_addr_i,
    output logic [7:0]       rd_data_o,
    output logic             cmd_valid_o,
    output logic [1:0]       cmd_op_o,
    output logic             cmd_start_o,
    output logic             cmd_stop_o,
    output logic             cmd_nack_o,
    output logic [7:0]       cmd_wdata_o,
    input  logic             cmd_done_i,
    input  logic             cmd_ack_i,
    input  logic [7:0]       cmd_rdata_i
);

    logic             cap_we;
    logic [IDX_W-1:0] cap_idx;
    logic             cs_clear, cs_add, cs_check, cs_mismatch;

    spd_sequencer #(
        .NUM_BYTES    (NUM_BYTES),
        .DEV_ADDR     (DEV_ADDR),
        .TIMEOUT_W    (TIMEOUT_W),
        .TIMEOUT_LIMIT(TIMEOUT_LIMIT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cmd_done_i   (cmd_done_i),
        .cmd_ack_i    (cmd_ack_i),
        .cs_mismatch_i(cs_mismatch),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .ok_o         (ok_o),
        .cks_err_o    (cksum_err_o),
        .to_err_o     (timeout_err_o),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_op_o     (cmd_op_o),
        .cmd_start_o  (cmd_start_o),
        .cmd_stop_o   (cmd_stop_o),
        .cmd_nack_o   (cmd_nack_o),
        .cmd_wdata_o  (cmd_wdata_o),
        .cap_we_o     (cap_we),
        .cap_idx_o    (cap_idx),
        .cs_clear_o   (cs_clear),
        .cs_add_o     (cs_add),
        .cs_check_o   (cs_check)
    );

    spd_checksum u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (cs_clear),
        .add_i     (cs_add),
        .check_i   (cs_check),
        .byte_i    (cmd_rdata_i),
        .mismatch_o(cs_mismatch)
    );

    spd_capture #(
        .NUM_BYTES(NUM_BYTES)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cap_we),
        .widx_i (cap_idx),
        .wdata_i(cmd_rdata_i),
        .raddr_i(rd_addr_i),
        .rdata_o(rd_data_o)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({ok_o, cksum_err_o, timeout_err_o}) == 1 && !busy_o)); // R9

    AST_FLAGS_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !ok_o && !cksum_err_o && !timeout_err_o)); // R1

endmodule

// File: tb/spd_eeprom_reader_tb.sv
module spd_eeprom_reader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, ok, cks_err, to_err;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic       cmd_start, cmd_stop, cmd_nack;
    logic [7:0] cmd_wdata;
    logic       cmd_done = 1'b0;
    logic       cmd_ack = 1'b0;
    logic [7:0] cmd_rdata = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spd_eeprom_reader #(
        .NUM_BYTES(64), .DEV_ADDR(8'hA2), .TIMEOUT_W(4), .TIMEOUT_LIMIT(LIMIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .busy_o(busy), .done_o(done), .ok_o(ok), .cksum_err_o(cks_err),
        .timeout_err_o(to_err), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_start_o(cmd_start),
        .cmd_stop_o(cmd_stop), .cmd_nack_o(cmd_nack), .cmd_wdata_o(cmd_wdata),
        .cmd_done_i(cmd_done), .cmd_ack_i(cmd_ack), .cmd_rdata_i(cmd_rdata)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // responder model state
    int         resp_delay = 0;
    int         nack_idx = -1;
    int         hang_idx = -1;
    int         ncmd = 0;
    int         ptr = 0;
    bit         ptr_armed = 0;
    logic [7:0] mem [64];
    logic [1:0] lop [128];
    logic       lst [128];
    logic       lsp [128];
    logic       lnk [128];
    logic [7:0] lwd [128];

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic serve();
        if (ncmd < 128) begin
            lop[ncmd] = cmd_op; lst[ncmd] = cmd_start; lsp[ncmd] = cmd_stop;
            lnk[ncmd] = cmd_nack; lwd[ncmd] = cmd_wdata;
        end
        cmd_ack = 1'b1;
        if (cmd_op == 2'd0) begin
            cmd_ack = (ncmd != nack_idx);
            if (cmd_start) begin
                ptr_armed = (cmd_wdata == 8'hA2);
            end else if (ptr_armed) begin
                ptr = int'(cmd_wdata);
                ptr_armed = 0;
            end
        end else if (cmd_op == 2'd1) begin
            cmd_rdata = mem[ptr % 64];
            ptr++;
        end
        ncmd++;
    endtask

    initial begin : responder
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (cmd_done) begin
                cmd_done = 1'b0;
                wcnt = 0;
            end
            if (!rst_n || !cmd_valid) begin
                wcnt = 0;
            end else if (ncmd == hang_idx) begin
                wcnt = 0;
            end else if (wcnt == resp_delay) begin
                serve();
                cmd_done = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic fill(input int seed, input bit corrupt);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < 63; i++) begin
            mem[i] = 8'((seed * 37 + i * i * 11 + 5) ^ (seed << 4));
            s = s + mem[i];
        end
        mem[63] = corrupt ? (s ^ (8'h01 << (seed % 8))) : s;
    endtask

    // outcome: 0 ok, 1 checksum error, 2 abort
    task automatic run(input int seed, input int dly, input bit corrupt,
                       input int nk, input int hg, input bit extra_start,
                       input int outcome, input string req);
        int cyc;
        fill(seed, corrupt);
        resp_delay = dly; nack_idx = nk; hang_idx = hg;
        ncmd = 0; ptr = 0; ptr_armed = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1", {busy, ok, cks_err, to_err}, 4'b1000, "busy/flags after start");
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start = (extra_start && cyc == 20);
        end
        start = 1'b0;
        chk("R9", done, 1'b1, "done seen");
        chk(req, {ok, cks_err, to_err}, (outcome == 0) ? 3'b100 :
            (outcome == 1) ? 3'b010 : 3'b001, "outcome flags");
        chk("R9", busy, 1'b0, "busy low with done");
        @(negedge clk);
        chk("R9", {done, ok, cks_err, to_err},
            {1'b0, (outcome == 0), (outcome == 1), (outcome == 2)}, "done pulse and held flags");
        hang_idx = -1; nack_idx = -1;
    endtask

    task automatic check_sequence(input string tag);
        bit bad;
        chk("R4", ncmd, 67, {tag, " command count"});
        chk("R2", {lop[0], lst[0], lsp[0], lwd[0]}, {2'd0, 1'b1, 1'b0, 8'hA2}, "address write cmd");
        chk("R2", {lop[1], lst[1], lsp[1], lwd[1]}, {2'd0, 1'b0, 1'b0, 8'h00}, "pointer write cmd");
        chk("R3", {lop[2], lst[2], lsp[2], lwd[2]}, {2'd0, 1'b1, 1'b0, 8'hA3}, "address read cmd");
        bad = 0;
        for (int i = 3; i < 67; i++) begin
            if ({lop[i], lst[i], lsp[i], lnk[i]} !==
                {2'd1, 1'b0, (i == 66), (i == 66)}) bad = 1;
        end
        chk("R4", bad, 1'b0, "read flags");
    endtask

    task automatic check_capture();
        int errs;
        errs = 0;
        for (int a = 0; a < 64; a++) begin
            rd_addr = 6'(a);
            #1;
            if (rd_data !== mem[a]) errs++;
        end
        chk("R5", errs, 0, "captured bytes mismatching");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int dlys [4];
        dlys = '{0, 1, 2, LIMIT - 1};
        repeat (3) @(negedge clk);
        chk("R9", {busy, done, ok, cks_err, to_err, cmd_valid}, 6'b0, "state in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", {busy, done, ok, cks_err, to_err, cmd_valid}, 6'b0, "idle after reset");

        // R6 sweep: seeds x delays x correct/corrupt checksum byte
        for (int seed = 0; seed < 8; seed++) begin
            for (int d = 0; d < 4; d++) begin
                for (int c = 0; c < 2; c++) begin
                    run(seed, dlys[d], c[0], -1, -1, 0, c, "R6");
                    check_sequence("R6");
                    check_capture();
                end
            end
        end

        // R7: delay equal to the limit aborts on the first command
        run(3, LIMIT, 0, -1, -1, 0, 2, "R7");
        chk("R7", ncmd, 0, "commands completed at limit delay");
        chk("R7", cmd_valid, 1'b0, "valid dropped after timeout");

        // R7: stall at various commands, no STOP follows
        foreach (dlys[k]) begin end
        for (int h = 0; h < 6; h++) begin
            int hs [6];
            hs = '{0, 1, 2, 3, 40, 66};
            run(h, 1, 0, -1, hs[h], 0, 2, "R7");
            chk("R7", ncmd, hs[h], "commands before stall abort");
            repeat (3) @(negedge clk);
            chk("R7", {cmd_valid, ncmd}, {1'b0, 32'(hs[h])}, "no command after abort");
        end

        // R8: missing acknowledge on each write step
        for (int n = 0; n < 3; n++) begin
            run(n, 0, 0, n, -1, 0, 2, "R8");
            chk("R8", ncmd, n + 2, "commands for nack abort");
            chk("R8", {lop[n + 1], lsp[n + 1]}, {2'd2, 1'b1}, "stop-only command after nack");
        end

        // R1: start while busy is ignored
        run(5, 1, 0, -1, -1, 1, 0, "R1");
        check_sequence("R1");
        check_capture();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule